// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Channel

This block is one audio DMA channel that works through a table of descriptors held in memory. Each descriptor is 64 bits wide. The first word is the start address of a byte segment. The second word holds three control bits at the top and a 24-bit byte length at the bottom. The channel reads a descriptor, streams its segment as 32-bit beats through a request/valid memory read port, and counts the remaining bytes down. When the segment ends it raises the events that the descriptor asks for. It then moves on to the next descriptor, 8 bytes further on.

Software sees four 32-bit registers, chosen by a 2-bit select. Writing one control word with start, loop and both interrupt enables set arms the channel. With loop set, an end-of-list descriptor sends the fetch back to the table base, so the table plays as a continuous ring. Status events are cleared by writing ones. The interrupt output is a level.

The controller is a five-state machine:
- **IDLE**: stopped.
- **ADDR**: reads the address word.
- **LEN**: reads the flags/length word.
- **XFER**: streams the beats.
- **DONE**: one cycle that posts the events and picks the next step.

Transitions:
- IDLE→ADDR on a start write.
- ADDR→LEN and LEN→XFER on a memory return.
- XFER→DONE when the remaining count is zero.
- DONE→ADDR for the next descriptor, or on a ring restart.
- DONE→IDLE on end-of-list without loop, on a stop-marked descriptor, or on a pending stop.
- ADDR, LEN or XFER→IDLE on a memory return while a stop is pending.

Top module: `sgdma_chan`

## Requirements
- R1: After reset all four registers read 0, `chan_active`, `irq`, `mem_req` and `data_valid` are low.
- R2: Register select 0 is the 32-bit table base. Select 1 is control: bit0 start, bit1 stop (both write-only pulses), bit2 loop, bit3 end-of-list interrupt enable, bit4 flag interrupt enable. A start write while idle fetches the descriptor word at base, then the word at base+4. `mem_req` stays high with a stable `mem_addr` until `mem_valid`.
- R3: A segment of length L is streamed as one beat per memory return, at addresses A, A+4, and so on, until the count reaches 0. The count drops by 4 per beat and saturates at 0, so a length of 6 gives 2 beats. `data_out` is the returned word.
- R4: After a descriptor that is neither end-of-list nor stop-marked, the next descriptor is fetched 8 bytes further on, and its index is one higher.
- R5: Select 3 reads the current descriptor index in bits 31:24 and the remaining bytes in bits 23:0. The index changes in the same cycle that the count reloads.
- R6: At segment end, descriptor bit 30 sets status bit1 (flag) and descriptor bit 31 sets status bit0 (end-of-list).
- R7: At an end-of-list descriptor the channel stops, unless loop is set. With loop set it restarts at the table base with index 0.
- R8: A descriptor with bit 29 set stops the channel after its segment, and its events are still posted. No later descriptor is streamed.
- R9: A zero-length descriptor produces no beat but still posts its events.
- R10: A stop write halts the channel at the next memory return or segment end. After that `mem_req` stays low.
- R11: Select 2 reads status: bit0 end-of-list, bit1 flag, bit2 interrupt pending, bit3 active. Writing 1 to bit0 or bit1 clears it. Writing 0 leaves it unchanged.
- R12: `irq` and the pending bit equal (end-of-list status AND its enable) OR (flag status AND its enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 32 | Memory read byte address |
| mem_valid | input | 1 | Memory read data returned |
| mem_rdata | input | 32 | Memory read data |
| data_valid | output | 1 | Audio beat valid |
| data_out | output | 32 | Audio beat data |
| chan_active | output | 1 | Channel running |
| irq | output | 1 | Level interrupt |

## Verification
The bench covers the following corner cases:
- **Length of 6.** A design that counts without saturating would wrap the 24-bit count and stream millions of beats.
- **Zero-length flag descriptor followed by a stop-marked one.** A design that skips the end-of-segment state for empty segments would lose the flag. One that ignores the stop bit would stream a third segment, which the scoreboard rejects as an extra beat.
- **Single-descriptor ring, then a stop write.** This shows that the index returns to 0 and that the ring can be halted. A wrong interrupt mask would show as `irq` high with the enables off.
- **Write-one-to-clear.** The bench clears the two status bits one at a time. A design that cleared both, or cleared on a zero write, would drop the interrupt too early.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LEN,
        ST_XFER,
        ST_DONE
    } sg_state_e;

    // descriptor flags-word bit positions
    localparam int DESC_EOL_BIT  = 31;
    localparam int DESC_FLAG_BIT = 30;
    localparam int DESC_STOP_BIT = 29;

    // register selects
    localparam logic [1:0] SEL_BASE   = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;
    localparam logic [1:0] SEL_COUNT  = 2'd3;

    // control bits
    localparam int CB_START   = 0;
    localparam int CB_STOP    = 1;
    localparam int CB_LOOP    = 2;
    localparam int CB_IE_EOL  = 3;
    localparam int CB_IE_FLAG = 4;

    // status bits
    localparam int SB_EOL     = 0;
    localparam int SB_FLAG    = 1;
    localparam int SB_PENDING = 2;
    localparam int SB_ACTIVE  = 3;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] base_o,
    output logic              loop_o,
    output logic              start_o,
    output logic              stop_o,
    input  logic              set_eol_i,
    input  logic              set_flag_i,
    input  logic              active_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  rem_i,
    output logic              irq_o
);

    logic              ie_eol, ie_flag;
    logic              st_eol, st_flag;
    logic              pending;
    logic              wr_ctrl, wr_stat;

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_stat = reg_wr && (reg_sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            loop_o  <= 1'b0;
            ie_eol  <= 1'b0;
            ie_flag <= 1'b0;
            st_eol  <= 1'b0;
            st_flag <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_BASE)
                base_o <= reg_wdata;
            if (wr_ctrl) begin
                loop_o  <= reg_wdata[CB_LOOP];
                ie_eol  <= reg_wdata[CB_IE_EOL];
                ie_flag <= reg_wdata[CB_IE_FLAG];
            end
            // a new event wins over a clear in the same cycle
            if (set_eol_i)
                st_eol <= 1'b1;
            else if (wr_stat && reg_wdata[SB_EOL])
                st_eol <= 1'b0;
            if (set_flag_i)
                st_flag <= 1'b1;
            else if (wr_stat && reg_wdata[SB_FLAG])
                st_flag <= 1'b0;
        end
    end

    assign start_o = wr_ctrl && reg_wdata[CB_START];
    assign stop_o  = wr_ctrl && reg_wdata[CB_STOP];
    assign pending = (st_eol && ie_eol) || (st_flag && ie_flag);
    assign irq_o   = pending;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_BASE: reg_rdata = base_o;
            SEL_CTRL: begin
                reg_rdata[CB_LOOP]    = loop_o;
                reg_rdata[CB_IE_EOL]  = ie_eol;
                reg_rdata[CB_IE_FLAG] = ie_flag;
            end
            SEL_STATUS: begin
                reg_rdata[SB_EOL]     = st_eol;
                reg_rdata[SB_FLAG]    = st_flag;
                reg_rdata[SB_PENDING] = pending;
                reg_rdata[SB_ACTIVE]  = active_i;
            end
            default: begin
                reg_rdata[CNT_W-1:0]      = rem_i;
                reg_rdata[CNT_W +: IDX_W] = idx_i;
            end
        endcase
    end

endmodule

// File: rtl/sgdma_fsm.sv
module sgdma_fsm
    import sgdma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int IDX_W      = 8,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              loop_i,
    input  logic [DATA_W-1:0] base_i,
    output logic              mem_req_o,
    output logic [DATA_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              beat_valid_o,
    output logic [DATA_W-1:0] beat_data_o,
    output logic              set_eol_o,
    output logic              set_flag_o,
    output logic              active_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [CNT_W-1:0]  rem_o
);

    localparam int          DESC_BYTES = 2 * (DATA_W / 8);
    localparam int          WORD_BYTES = DATA_W / 8;
    localparam logic [CNT_W-1:0] STEP  = CNT_W'(BEAT_BYTES);

    sg_state_e         state, state_nx;
    logic [DATA_W-1:0] desc_ptr, seg_addr;
    logic [CNT_W-1:0]  rem;
    logic [IDX_W-1:0]  slot, idx;
    logic              d_eol, d_flag, d_stop;
    logic              stop_req;
    logic              halt;
    logic              rem_zero;

    assign halt     = stop_req || stop_i;
    assign rem_zero = (rem == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (start_i && !stop_i) state_nx = ST_ADDR;
            ST_ADDR:
                if (mem_valid_i) state_nx = halt ? ST_IDLE : ST_LEN;
            ST_LEN:
                if (mem_valid_i) state_nx = halt ? ST_IDLE : ST_XFER;
            ST_XFER:
                if (rem_zero)         state_nx = ST_DONE;
                else if (mem_valid_i) state_nx = halt ? ST_IDLE : ST_XFER;
            ST_DONE:
                if (halt || d_stop)   state_nx = ST_IDLE;
                else if (d_eol)       state_nx = loop_i ? ST_ADDR : ST_IDLE;
                else                  state_nx = ST_ADDR;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_ptr <= '0;
            seg_addr <= '0;
            rem      <= '0;
            slot     <= '0;
            idx      <= '0;
            d_eol    <= 1'b0;
            d_flag   <= 1'b0;
            d_stop   <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            if (state_nx == ST_IDLE)
                stop_req <= 1'b0;
            else if (stop_i)
                stop_req <= 1'b1;

            unique case (state)
                ST_IDLE: if (start_i && !stop_i) begin
                    desc_ptr <= base_i;
                    slot     <= '0;
                    idx      <= '0;
                    rem      <= '0;
                end
                ST_ADDR: if (mem_valid_i)
                    seg_addr <= mem_rdata_i;
                ST_LEN: if (mem_valid_i) begin
                    rem    <= mem_rdata_i[CNT_W-1:0];
                    idx    <= slot;
                    d_eol  <= mem_rdata_i[DESC_EOL_BIT];
                    d_flag <= mem_rdata_i[DESC_FLAG_BIT];
                    d_stop <= mem_rdata_i[DESC_STOP_BIT];
                end
                ST_XFER: if (!rem_zero && mem_valid_i) begin
                    seg_addr <= seg_addr + DATA_W'(BEAT_BYTES);
                    rem      <= (rem < STEP) ? '0 : rem - STEP;
                end
                ST_DONE: if (!halt && !d_stop) begin
                    if (d_eol) begin
                        desc_ptr <= base_i;
                        slot     <= '0;
                    end else begin
                        desc_ptr <= desc_ptr + DATA_W'(DESC_BYTES);
                        slot     <= slot + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o    = 1'b0;
        mem_addr_o   = '0;
        beat_valid_o = 1'b0;
        set_eol_o    = 1'b0;
        set_flag_o   = 1'b0;
        unique case (state)
            ST_ADDR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_ptr;
            end
            ST_LEN: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_ptr + DATA_W'(WORD_BYTES);
            end
            ST_XFER: begin
                mem_req_o    = !rem_zero;
                mem_addr_o   = seg_addr;
                beat_valid_o = !rem_zero && mem_valid_i;
            end
            ST_DONE: begin
                set_eol_o  = d_eol;
                set_flag_o = d_flag;
            end
            default: ;
        endcase
    end

    assign beat_data_o = mem_rdata_i;
    assign active_o    = (state != ST_IDLE);
    assign idx_o       = idx;
    assign rem_o       = rem;

endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
    import sgdma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int IDX_W      = 8,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic              chan_active,
    output logic              irq
);

    logic [DATA_W-1:0] base;
    logic              loop_en, start_p, stop_p;
    logic              set_eol, set_flag;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  rem;

    sgdma_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .base_o(base), .loop_o(loop_en), .start_o(start_p), .stop_o(stop_p),
        .set_eol_i(set_eol), .set_flag_i(set_flag), .active_i(chan_active),
        .idx_i(idx), .rem_i(rem), .irq_o(irq)
    );

    sgdma_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
                .BEAT_BYTES(BEAT_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_p), .stop_i(stop_p), .loop_i(loop_en), .base_i(base),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
        .beat_valid_o(data_valid), .beat_data_o(data_out),
        .set_eol_o(set_eol), .set_flag_o(set_flag),
        .active_o(chan_active), .idx_o(idx), .rem_o(rem)
    );

endmodule

// File: rtl/sgdma_chan_chk.sv
module sgdma_chan_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              data_valid,
    input logic              chan_active,
    input logic              irq
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    // R3
    beat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> mem_valid && mem_req);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_active |-> !mem_req && !data_valid);

    // R2
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == 2'd1 && reg_wdata[0] && !reg_wdata[1] && !chan_active
        |=> chan_active);

    // R1
    rst_irq_chk: assert property (@(posedge clk)
        !rst_n |=> !irq && !chan_active);

endmodule

bind sgdma_chan sgdma_chan_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sgdma_chan_bench.sv
module sgdma_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        data_valid;
    logic [31:0] data_out;
    logic        chan_active;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int beats  = 0;
    logic [31:0] exp_q[$];
    logic [31:0] img [logic [31:0]];

    always #5 clk = ~clk;

    sgdma_chan u_sgdma_chan (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hA5A5_0000;
    endfunction

    // memory model: one-cycle latency, one response per request
    always @(posedge clk) begin
        mem_valid <= mem_req && !mem_valid;
        mem_rdata <= img.exists(mem_addr) ? img[mem_addr] : pat(mem_addr);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && data_valid) begin
            beats++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 extra beat act=%h exp=none", data_out);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (data_out !== e) begin
                    errors++;
                    $display("FAIL R3 beat act=%h exp=%h", data_out, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic expect_seg(input logic [31:0] a, input int len);
        for (int off = 0; off < len; off += 4) exp_q.push_back(pat(a + off));
    endtask

    task automatic wait_idle(input int lim, output int n);
        n = 0;
        while (chan_active && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n, b0;

        // descriptor tables
        img[32'h1000] = 32'h2000; img[32'h1004] = 32'h4000_0008;          // flag, 8 bytes
        img[32'h1008] = 32'h3000; img[32'h100C] = 32'h8000_0006;          // eol, 6 bytes
        img[32'h1100] = 32'h4100; img[32'h1104] = 32'h4000_0000;          // flag, empty
        img[32'h1108] = 32'h4000; img[32'h110C] = 32'h2000_0004;          // stop, 4 bytes
        img[32'h1110] = 32'h4800; img[32'h1114] = 32'h8000_0004;          // never reached
        img[32'h1200] = 32'h5000; img[32'h1204] = 32'hC000_0004;          // eol+flag ring

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq/active", {30'd0, irq, chan_active}, 32'h0);

        // T1: two descriptors, no loop, both interrupts enabled
        wr(2'd0, 32'h1000);
        rd(2'd0, v);
        check("R2 base readback", v, 32'h1000);
        expect_seg(32'h2000, 8);
        expect_seg(32'h3000, 6);
        wr(2'd1, 32'h19);                                 // start|ie_eol|ie_flag
        rd(2'd1, v);
        check("R2 ctrl readback", v, 32'h18);
        wait_idle(500, n);
        check("R7 stopped at eol", {31'd0, chan_active}, 32'h0);
        check("R3 R4 all beats seen", exp_q.size(), 0);
        rd(2'd2, v);
        check("R6 R11 status eol+flag", v, 32'h7);
        check("R12 irq set", {31'd0, irq}, 32'h1);
        rd(2'd3, v);
        check("R5 index/remaining", v, 32'h0100_0000);
        wr(2'd2, 32'h0);
        rd(2'd2, v);
        check("R11 zero write keeps", v, 32'h7);
        wr(2'd2, 32'h2);
        rd(2'd2, v);
        check("R11 clear flag only", v, 32'h5);
        check("R12 irq from eol", {31'd0, irq}, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v);
        check("R11 clear eol", v, 32'h0);
        check("R12 irq dropped", {31'd0, irq}, 32'h0);

        // T2: empty flag descriptor then stop-marked one; flag interrupt only
        wr(2'd0, 32'h1100);
        expect_seg(32'h4000, 4);
        wr(2'd1, 32'h11);                                 // start|ie_flag
        wait_idle(500, n);
        repeat (10) @(negedge clk);
        check("R8 halted", {31'd0, chan_active}, 32'h0);
        check("R8 R9 beats only from stop segment", exp_q.size(), 0);
        rd(2'd2, v);
        check("R9 flag from empty descriptor", v, 32'h6);
        check("R12 flag irq", {31'd0, irq}, 32'h1);
        rd(2'd3, v);
        check("R5 R4 index after stop", v, 32'h0100_0000);
        // reset sequence: stop, control zero, clear events
        wr(2'd1, 32'h2);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h3);
        rd(2'd2, v);
        check("R11 reset sequence status", v, 32'h0);

        // T3: single-descriptor ring, interrupts disabled
        wr(2'd0, 32'h1200);
        for (int k = 0; k < 40; k++) exp_q.push_back(pat(32'h5000));
        b0 = beats;
        wr(2'd1, 32'h5);                                  // start|loop
        n = 0;
        while (beats - b0 < 3 && n < 500) begin
            @(negedge clk);
            n++;
        end
        check("R7 ring repeats", (beats - b0 >= 3) ? 32'h1 : 32'h0, 32'h1);
        rd(2'd2, v);
        check("R7 R12 status masked", v, 32'hB);
        check("R12 irq masked", {31'd0, irq}, 32'h0);
        rd(2'd3, v);
        check("R7 index wraps", {24'd0, v[31:24]}, 32'h0);
        wr(2'd1, 32'h2);                                  // stop
        wait_idle(8, n);
        check("R10 halts promptly", {31'd0, chan_active}, 32'h0);
        b0 = beats;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_req) n++;
        end
        check("R10 no requests after stop", n, 0);
        check("R10 no beats after stop", beats - b0, 0);
        exp_q.delete();

        finish_run();
    end

endmodule